// File: doc/BRIEF.md
# Indirect PHY Control-Register Handshake Master

This block reads and writes a PHY's 16-bit control registers through an indirect port. The PHY has one data-in bus, one data-out bus, four trigger strobes (capture address, capture data, read, write) and a single acknowledge line. A host issues one operation at a time over a valid/ready request interface, giving the direction, a 16-bit register address and, for writes, 16-bit data. The block carries out the whole exchange with the PHY and reports completion with a one-cycle done pulse. Read data and a timeout error flag come back alongside it.

Every operation has two accesses. First comes an address access: the address is placed on the data-in bus and the capture-address strobe is pulsed. Then comes a data access: the write data, or zero for a read, is placed on the bus, the capture-data strobe is pulsed, and then the write or read strobe. Each strobe is a full four-phase handshake. The strobe rises and waits for acknowledge high, then falls and waits for acknowledge low. Each wait has a bounded length. When a wait runs out, the block records an error and carries on. Fixed, parameterised idle gaps follow each handshake edge and each strobe.

Top module: `crport_master`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1, all four strobes are 0, and `done` and `timeout_err` are 0.
- R2: A write performs three strobes in this order: capture-address with `phy_din` equal to the address, capture-data with `phy_din` equal to the write data, and write with `phy_din` still equal to the write data. A later read of that address returns the written value.
- R3: A read performs three strobes in this order: capture-address with `phy_din` equal to the address, then capture-data and then read, both with `phy_din` equal to 0. `rd_data` equals the value on `phy_dout` in the cycle in which the read strobe's acknowledge is seen low. It is held until the next read completes.
- R4: At most one strobe is high at a time, and `phy_din` is stable while any strobe is high. A strobe never rises while acknowledge is high. When the PHY answers, a strobe never falls before acknowledge has been seen high.
- R5: Between one strobe falling and the next one rising there are at least EDGE_GAP+PHASE_GAP cycles with all strobes low.
- R6: If acknowledge never rises, each strobe stays high for exactly TIMEOUT_CYC+EDGE_GAP cycles. The operation still completes with all three strobes, and `timeout_err` is 1 together with `done`. An operation whose handshakes all finish leaves `timeout_err` at 0.
- R7: `req_ready` is 0 from the cycle after a request is accepted until `done`. `done` is high for exactly one cycle. A request held high while the block is busy starts no second operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | An acknowledge wait expired during the last operation |
| rd_data | output | 16 | Data of the last completed read |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_rd | output | 1 | Read strobe |
| phy_wr | output | 1 | Write strobe |
| phy_din | output | 16 | Data-in bus to the PHY |
| phy_ack | input | 1 | PHY acknowledge |
| phy_dout | input | 16 | Data-out bus from the PHY |

## Verification
The assertions assume that the host keeps request fields steady only in the accept cycle, since the block latches them there. They also assume that the PHY lowers acknowledge only after its strobe has fallen, so `phy_din` stability and strobe exclusivity are checked against strobes alone. The bench PHY model raises acknowledge a programmable number of cycles after a strobe rises and drops it the same delay after the strobe falls. It holds `phy_dout` from the read strobe onward, and it can be made unresponsive to exercise the timeout path. Requests are driven on falling edges and only while `req_ready` is high, apart from one test that deliberately holds `req_valid` through a busy period.

// File: rtl/crport_pkg.sv
package crport_pkg;
  localparam int NUM_STB = 4;
  localparam int SEL_W   = $clog2(NUM_STB);

  // strobe index; the decode order fixes which output pin each one drives
  typedef enum logic [SEL_W-1:0] {
    STB_CAP_ADDR = 2'd0,
    STB_CAP_DATA = 2'd1,
    STB_READ     = 2'd2,
    STB_WRITE    = 2'd3
  } stb_sel_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RISE_WAIT, PH_RISE_GAP, PH_FALL_WAIT, PH_FALL_GAP, PH_TAIL
  } phase_st_e;

  typedef enum logic [1:0] {
    OP_IDLE, OP_ADDR, OP_CAPD, OP_XFER
  } op_st_e;
endpackage

// File: rtl/crport_phase.sv
module crport_phase
  import crport_pkg::*;
#(
  parameter int TIMEOUT_CYC = 100,
  parameter int EDGE_GAP    = 2,
  parameter int PHASE_GAP   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack,
  output logic trig,
  output logic sample,
  output logic tmo,
  output logic fin
);
  localparam int MAXA = (TIMEOUT_CYC > EDGE_GAP) ? TIMEOUT_CYC : EDGE_GAP;
  localparam int MAXC = (MAXA > PHASE_GAP) ? MAXA : PHASE_GAP;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] T_LAST = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] E_LAST = CW'(EDGE_GAP - 1);
  localparam logic [CW-1:0] P_LAST = CW'(PHASE_GAP - 1);

  phase_st_e st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= PH_IDLE;
      cnt  <= '0;
      trig <= 1'b0;
    end else begin
      case (st)
        PH_IDLE: begin
          cnt <= '0;
          if (start) begin
            trig <= 1'b1;
            st   <= PH_RISE_WAIT;
          end
        end
        PH_RISE_WAIT:
          if (ack || cnt == T_LAST) begin
            st <= PH_RISE_GAP; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        PH_RISE_GAP:
          if (cnt == E_LAST) begin
            trig <= 1'b0; st <= PH_FALL_WAIT; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        PH_FALL_WAIT:
          if (!ack || cnt == T_LAST) begin
            st <= PH_FALL_GAP; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        PH_FALL_GAP:
          if (cnt == E_LAST) begin
            st <= PH_TAIL; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        PH_TAIL:
          if (cnt == P_LAST) begin
            st <= PH_IDLE; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign sample = (st == PH_FALL_WAIT) && (!ack || cnt == T_LAST);
  assign tmo    = ((st == PH_RISE_WAIT) && !ack && cnt == T_LAST) ||
                  ((st == PH_FALL_WAIT) &&  ack && cnt == T_LAST);
  assign fin    = (st == PH_TAIL) && (cnt == P_LAST);

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (st == PH_IDLE));
  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_RISE_WAIT || st == PH_FALL_WAIT) |-> (cnt <= T_LAST));
  // R4
  drop_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_RISE_WAIT && ack) |=> trig);
endmodule

// File: rtl/crport_strobe_dec.sv
module crport_strobe_dec
  import crport_pkg::*;
#(
  parameter int N = NUM_STB
) (
  input  logic                       trig,
  input  logic [$clog2(N)-1:0]       sel,
  output logic [N-1:0]               stb
);
  localparam int SW = $clog2(N);
  for (genvar i = 0; i < N; i++) begin : g_stb
    assign stb[i] = trig && (sel == SW'(i));
  end
endmodule

// File: rtl/crport_master.sv
module crport_master
  import crport_pkg::*;
#(
  parameter int DW          = 16,
  parameter int TIMEOUT_CYC = 100,
  parameter int EDGE_GAP    = 2,
  parameter int PHASE_GAP   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          timeout_err,
  output logic [DW-1:0] rd_data,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_rd,
  output logic          phy_wr,
  output logic [DW-1:0] phy_din,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_dout
);
  op_st_e        st;
  logic          op_wr, go, err_acc;
  logic [DW-1:0] wdata_q;
  stb_sel_e      sel_q;
  logic          trig, sample, tmo, fin;
  logic [NUM_STB-1:0] stb;

  crport_phase #(
    .TIMEOUT_CYC(TIMEOUT_CYC), .EDGE_GAP(EDGE_GAP), .PHASE_GAP(PHASE_GAP)
  ) u_phase (
    .clk(clk), .rst(rst), .start(go), .ack(phy_ack),
    .trig(trig), .sample(sample), .tmo(tmo), .fin(fin)
  );

  crport_strobe_dec #(.N(NUM_STB)) u_dec (
    .trig(trig), .sel(sel_q), .stb(stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= OP_IDLE;
      op_wr       <= 1'b0;
      go          <= 1'b0;
      err_acc     <= 1'b0;
      wdata_q     <= '0;
      sel_q       <= STB_CAP_ADDR;
      phy_din     <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      rd_data     <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      if (tmo) err_acc <= 1'b1;
      case (st)
        OP_IDLE:
          if (req_valid) begin
            op_wr       <= req_write;
            wdata_q     <= req_wdata;
            phy_din     <= req_addr;
            sel_q       <= STB_CAP_ADDR;
            err_acc     <= 1'b0;
            timeout_err <= 1'b0;
            go          <= 1'b1;
            st          <= OP_ADDR;
          end
        OP_ADDR:
          if (fin) begin
            phy_din <= op_wr ? wdata_q : '0;
            sel_q   <= STB_CAP_DATA;
            go      <= 1'b1;
            st      <= OP_CAPD;
          end
        OP_CAPD:
          if (fin) begin
            sel_q <= op_wr ? STB_WRITE : STB_READ;
            go    <= 1'b1;
            st    <= OP_XFER;
          end
        OP_XFER: begin
          if (sample && !op_wr) rd_data <= phy_dout;
          if (fin) begin
            done        <= 1'b1;
            timeout_err <= err_acc;
            st          <= OP_IDLE;
          end
        end
        default: st <= OP_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == OP_IDLE);
  assign phy_cap_addr = stb[STB_CAP_ADDR];
  assign phy_cap_data = stb[STB_CAP_DATA];
  assign phy_rd       = stb[STB_READ];
  assign phy_wr       = stb[STB_WRITE];

  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({phy_cap_addr, phy_cap_data, phy_rd, phy_wr}));
  // R4
  din_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (phy_cap_addr || phy_cap_data || phy_rd || phy_wr) |-> $stable(phy_din));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !(phy_cap_addr || phy_cap_data || phy_rd || phy_wr));
  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> done);
endmodule

// File: tb/crport_master_bench.sv
`timescale 1ns/1ps
module crport_master_bench;
  localparam int DW = 16, TO = 100, EG = 2, PG = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [DW-1:0] req_addr = '0, req_wdata = '0;
  logic req_ready, done, timeout_err;
  logic [DW-1:0] rd_data, phy_din;
  logic phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
  logic phy_ack = 1'b0;
  logic [DW-1:0] phy_dout = '0;

  always #5 clk = ~clk;

  crport_master #(.DW(DW), .TIMEOUT_CYC(TO), .EDGE_GAP(EG), .PHASE_GAP(PG)) u_crport_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .timeout_err(timeout_err), .rd_data(rd_data),
    .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
    .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_din(phy_din),
    .phy_ack(phy_ack), .phy_dout(phy_dout)
  );

  int nchk = 0, nfail = 0, cycles = 0;

  // PHY model: codes 0 cap-addr, 1 cap-data, 2 read, 3 write
  logic [3:0] stb, prev_stb = '0;
  assign stb = {phy_wr, phy_rd, phy_cap_data, phy_cap_addr};
  logic [DW-1:0] mem [16];
  logic [DW-1:0] a_reg = '0, d_reg = '0;
  int ack_dly = 3, dcnt = 0;
  logic dead = 1'b0;

  int log_code [64];
  logic [DW-1:0] log_din [64];
  int log_n = 0, low_cnt = 100, hi_len = 0, last_hi = 0;
  int hs_viol = 0, gap_viol = 0;
  logic saw_ack = 1'b0;

  initial for (int i = 0; i < 16; i++) mem[i] = 16'hA000 + 16'(i);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      phy_ack <= 1'b0; dcnt <= 0;
    end else begin
      if ((stb != 0) != phy_ack && !(dead && stb != 0)) begin
        if (dcnt >= ack_dly - 1) begin phy_ack <= (stb != 0); dcnt <= 0; end
        else dcnt <= dcnt + 1;
      end else dcnt <= 0;
      for (int i = 0; i < 4; i++) if (stb[i] && !prev_stb[i]) begin
        case (i)
          0: a_reg <= phy_din;
          1: d_reg <= phy_din;
          2: phy_dout <= mem[a_reg[3:0]];
          default: mem[a_reg[3:0]] <= d_reg;
        endcase
        if (log_n < 64) begin log_code[log_n] <= i; log_din[log_n] <= phy_din; end
        log_n <= log_n + 1;
        if (phy_ack) hs_viol <= hs_viol + 1;
        if (low_cnt < EG + PG) gap_viol <= gap_viol + 1;
      end
      if ($countones(stb) > 1) hs_viol <= hs_viol + 1;
      if (stb != 0) begin
        hi_len <= hi_len + 1; low_cnt <= 0;
        if (phy_ack) saw_ack <= 1'b1;
      end else begin
        low_cnt <= low_cnt + 1;
        if (prev_stb != 0) begin
          last_hi <= hi_len;
          if (!saw_ack && !dead) hs_viol <= hs_viol + 1;
        end
        hi_len <= 0; saw_ack <= 1'b0;
      end
    end
    prev_stb <= stb;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(posedge clk) if (cycles == 150000) begin
    nfail++; nchk++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  // run one operation; hold keeps req_valid high until done
  task automatic do_op(input bit w, input logic [15:0] a, input logic [15:0] d,
                       input bit hold, output logic [15:0] rdat, output bit terr,
                       output int first);
    int n;
    while (!req_ready) @(negedge clk);
    first = log_n;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    check(req_ready == 1'b0, "R7 busy ready", int'(req_ready), 0);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    req_valid = 1'b0;
    rdat = rd_data; terr = timeout_err;
    check(done == 1'b1, "R7 done seen", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check(stb == 4'b0, "R1 strobes", int'(stb), 0);
    check(done == 1'b0 && timeout_err == 1'b0, "R1 done/err", int'({done, timeout_err}), 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] r; bit e; int f;
    do_op(1'b1, a, d, 1'b0, r, e, f);
    check(log_n - f == 3, "R2 strobe count", log_n - f, 3);
    check(log_code[f] == 0 && log_code[f+1] == 1 && log_code[f+2] == 3, "R2 order",
          log_code[f]*100 + log_code[f+1]*10 + log_code[f+2], 13);
    check(log_din[f] == a, "R2 addr on din", int'(log_din[f]), int'(a));
    check(log_din[f+1] == d && log_din[f+2] == d, "R2 data on din", int'(log_din[f+2]), int'(d));
    check(e == 1'b0, "R6 no error", int'(e), 0);
  endtask

  task automatic t_read(input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] r; bit e; int f;
    do_op(1'b0, a, 16'hFFFF, 1'b0, r, e, f);
    check(log_n - f == 3 && log_code[f] == 0 && log_code[f+1] == 1 && log_code[f+2] == 2,
          "R3 order", log_code[f+2], 2);
    check(log_din[f] == a, "R3 addr on din", int'(log_din[f]), int'(a));
    check(log_din[f+1] == 0 && log_din[f+2] == 0, "R3 zero din", int'(log_din[f+1]), 0);
    check(r == exp, "R3 read data", int'(r), int'(exp));
  endtask

  task automatic t_busy_hold();
    logic [15:0] r; bit e; int f, caps;
    do_op(1'b1, 16'h0007, 16'h5A5A, 1'b1, r, e, f);
    caps = 0;
    for (int i = f; i < log_n; i++) if (log_code[i] == 0) caps++;
    check(caps == 1, "R7 held request single op", caps, 1);
    check(req_ready == 1'b1, "R7 idle after done", int'(req_ready), 1);
  endtask

  task automatic t_timeout();
    logic [15:0] r; bit e; int f;
    dead = 1'b1;
    do_op(1'b1, 16'h0002, 16'h1111, 1'b0, r, e, f);
    check(e == 1'b1, "R6 timeout flagged", int'(e), 1);
    check(log_n - f == 3, "R6 all strobes run", log_n - f, 3);
    check(last_hi == TO + EG, "R6 strobe hold", last_hi, TO + EG);
    dead = 1'b0;
    repeat (10) @(negedge clk);
    do_op(1'b0, 16'h0002, 16'h0, 1'b0, r, e, f);
    check(e == 1'b0, "R6 error cleared", int'(e), 0);
    check(r == 16'h1111, "R6 write landed", int'(r), 16'h1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(16'h0005, 16'h1234);
    t_read(16'h0005, 16'h1234);
    t_read(16'h0009, 16'hA009);
    t_write(16'h000C, 16'hBEEF);
    t_write(16'h0005, 16'h00FF);
    t_read(16'h000C, 16'hBEEF);
    t_read(16'h0005, 16'h00FF);
    ack_dly = 7;
    t_write(16'h0003, 16'hC0DE);
    t_read(16'h0003, 16'hC0DE);
    ack_dly = 1;
    t_read(16'h0003, 16'hC0DE);
    t_busy_hold();
    t_read(16'h0007, 16'h5A5A);
    t_timeout();
    check(hs_viol == 0, "R4 handshake order", hs_viol, 0);
    check(gap_viol == 0, "R5 strobe gaps", gap_viol, 0);
    summary();
  end
endmodule